// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order pipeline. It decides, separately for each of the two ALU inputs, where the operand comes from. It has three possible sources:

- the value read from the register file during decode;
- the ALU result of the instruction one step ahead, waiting in the memory stage;
- the value about to be written back by the instruction two steps ahead.

It outputs a 2-bit select code for each operand and the resolved operand word itself.

The block is purely combinational, so its outputs follow its inputs within the same cycle. A producer stage is a candidate only when it will write a register and its destination is not the hardwired zero register. When both producer stages target the register an operand reads, the younger result in the memory stage is chosen. This keeps the latest value visible to back-to-back writers of one register.

Top module: `fwd_unit`

## Requirements
- R1: When neither producer stage qualifies for an operand, its select is 2'b00 and the operand equals its register-file value.
- R2: When the memory-stage producer has its write enable high, a nonzero destination, and a destination equal to the operand's source register, the select is 2'b10 and the operand equals the memory-stage ALU result.
- R3: When only the write-back producer qualifies under the same three conditions, the select is 2'b01 and the operand equals the write-back value.
- R4: A producer whose write enable is low is never selected, even when its destination matches.
- R5: A destination of register 0 is never selected from either producer, even with write enable high.
- R6: When both producers qualify for the same operand, the memory-stage result wins (select 2'b10).
- R7: Operand A is decided from source field `src_a` only and operand B from `src_b` only, so the two operands may take different sources in the same cycle.
- R8: The select value 2'b11 never appears on either select output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | Source register number for ALU operand A |
| src_b | input | 5 | Source register number for ALU operand B |
| rf_a | input | 32 | Register-file value for operand A |
| rf_b | input | 32 | Register-file value for operand B |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register number |
| mem_res | input | 32 | Memory-stage ALU result |
| wb_wen | input | 1 | Write-back-stage instruction writes a register |
| wb_dst | input | 5 | Write-back-stage destination register number |
| wb_res | input | 32 | Write-back value |
| sel_a | output | 2 | Source select for operand A (00 file, 10 memory stage, 01 write-back) |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |

## Verification
The first pattern set has no match at all. Separate sets match only the memory stage and only the write-back stage, which shows the three sources apart through distinct data words. Patterns with a matching destination but write enable low, or with register 0 as the match, show that the qualifying conditions are applied and not just the number comparison. Dual-match patterns test the priority, and split patterns (A matching one stage, B the other) show that the two operands are independent. A sweep over source and destination numbers with varied enables is compared against a reference computed in the bench.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source select; encoding is fixed by the mux control contract.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10,
        SEL_RSV = 2'b11
    } fwd_sel_e;

    // Priority rule: the younger producer is consulted first.
    function automatic fwd_sel_e pick_source(input logic hit_mem, input logic hit_wb);
        if (hit_mem)     return SEL_MEM;
        else if (hit_wb) return SEL_WB;
        else             return SEL_RF;
    endfunction

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              wen,
    input  logic [REG_AW-1:0] dst,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wen && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/fwd_omux.sv
module fwd_omux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] out
);
    always_comb begin
        unique case (sel)
            SEL_MEM: out = mem_val;
            SEL_WB:  out = wb_val;
            default: out = rf_val;   // SEL_RF and the unused code fall back to the file
        endcase
    end
endmodule

// File: rtl/fwd_lane.sv
module fwd_lane
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] src,
    input  logic [DATA_W-1:0] rf_val,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic [DATA_W-1:0] mem_val,
    input  logic              wb_wen,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic [DATA_W-1:0] wb_val,
    output fwd_sel_e          sel,
    output logic [DATA_W-1:0] opnd
);
    logic hit_mem;
    logic hit_wb;

    fwd_hit #(.REG_AW(REG_AW)) u_hit_mem (
        .src(src), .wen(mem_wen), .dst(mem_dst), .hit(hit_mem)
    );

    fwd_hit #(.REG_AW(REG_AW)) u_hit_wb (
        .src(src), .wen(wb_wen), .dst(wb_dst), .hit(hit_wb)
    );

    always_comb begin
        sel = pick_source(hit_mem, hit_wb);
    end

    fwd_omux #(.DATA_W(DATA_W)) u_mux (
        .sel(sel), .rf_val(rf_val), .mem_val(mem_val), .wb_val(wb_val), .out(opnd)
    );

    // Port-level checks on the lane.
    always_comb begin
        a_r8_no_reserved: assert (sel != SEL_RSV)
            else $error("R8 reserved select produced");
        if (sel == SEL_MEM) begin
            a_r2_mem_qualified: assert (mem_wen && mem_dst != '0 && mem_dst == src)
                else $error("R2 memory-stage select without qualifying producer");
            a_r2_mem_data: assert (opnd == mem_val)
                else $error("R2 operand not memory-stage result");
        end
        if (sel == SEL_WB) begin
            a_r3_wb_qualified: assert (wb_wen && wb_dst != '0 && wb_dst == src)
                else $error("R3 write-back select without qualifying producer");
            a_r6_wb_only_if_mem_idle: assert (!(mem_wen && mem_dst != '0 && mem_dst == src))
                else $error("R6 write-back chosen over qualifying memory stage");
        end
        if (sel == SEL_RF) begin
            a_r1_rf_data: assert (opnd == rf_val)
                else $error("R1 operand not register-file value");
        end
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] src_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic [DATA_W-1:0] mem_res,
    input  logic              wb_wen,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic [DATA_W-1:0] wb_res,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NUM_OPS = 2;

    logic [REG_AW-1:0] src_v  [NUM_OPS];
    logic [DATA_W-1:0] rf_v   [NUM_OPS];
    fwd_sel_e          sel_v  [NUM_OPS];
    logic [DATA_W-1:0] opnd_v [NUM_OPS];

    always_comb begin
        src_v[0] = src_a;
        src_v[1] = src_b;
        rf_v[0]  = rf_a;
        rf_v[1]  = rf_b;
    end

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_lane
        fwd_lane #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_lane (
            .src(src_v[i]), .rf_val(rf_v[i]),
            .mem_wen(mem_wen), .mem_dst(mem_dst), .mem_val(mem_res),
            .wb_wen(wb_wen), .wb_dst(wb_dst), .wb_val(wb_res),
            .sel(sel_v[i]), .opnd(opnd_v[i])
        );
    end

    always_comb begin
        sel_a  = sel_v[0];
        sel_b  = sel_v[1];
        opnd_a = opnd_v[0];
        opnd_b = opnd_v[1];
    end

    // R7: operand B never follows A's source field when the fields differ.
    always_comb begin
        if (src_a != src_b && sel_b == SEL_MEM) begin
            a_r7_lane_b_own_field: assert (mem_dst == src_b)
                else $error("R7 operand B forwarded on operand A's register");
        end
    end
endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0]  src_a = '0, src_b = '0, mem_dst = '0, wb_dst = '0;
    logic [31:0] rf_a = '0, rf_b = '0, mem_res = '0, wb_res = '0;
    logic        mem_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int n_run = 0;
    int n_fail = 0;

    fwd_unit u_fwd_unit (
        .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
        .mem_wen(mem_wen), .mem_dst(mem_dst), .mem_res(mem_res),
        .wb_wen(wb_wen), .wb_dst(wb_dst), .wb_res(wb_res),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    localparam logic [31:0] RF_A = 32'hA0A0_0001, RF_B = 32'hB0B0_0002;
    localparam logic [31:0] MEMV = 32'h1111_CAFE, WBV  = 32'h2222_BEEF;

    function automatic logic [1:0] ref_sel(input logic [4:0] s);
        if (mem_wen && mem_dst != 0 && mem_dst == s) return 2'b10;
        if (wb_wen && wb_dst != 0 && wb_dst == s)    return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] ref_val(input logic [1:0] sel, input logic [31:0] rf);
        case (sel)
            2'b10:   return MEMV;
            2'b01:   return WBV;
            default: return rf;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] sa, input logic [4:0] sb,
                         input logic mw, input logic [4:0] md,
                         input logic ww, input logic [4:0] wd);
        @(negedge clk);
        src_a = sa; src_b = sb; mem_wen = mw; mem_dst = md; wb_wen = ww; wb_dst = wd;
        rf_a = RF_A; rf_b = RF_B; mem_res = MEMV; wb_res = WBV;
        #1;
    endtask

    task automatic check_both(input string req, input logic [1:0] ea, input logic [1:0] eb);
        check({req, " sel_a"}, {30'b0, sel_a}, {30'b0, ea});
        check({req, " sel_b"}, {30'b0, sel_b}, {30'b0, eb});
        check({req, " opnd_a"}, opnd_a, ref_val(ea, RF_A));
        check({req, " opnd_b"}, opnd_b, ref_val(eb, RF_B));
    endtask

    task automatic t_idle();                // R1
        apply(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
        check_both("R1 idle", 2'b00, 2'b00);
        apply(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd9);
        check_both("R1 no match", 2'b00, 2'b00);
    endtask

    task automatic t_mem_only();            // R2
        apply(5'd5, 5'd6, 1'b1, 5'd5, 1'b0, 5'd0);
        check_both("R2 mem on A", 2'b10, 2'b00);
        apply(5'd6, 5'd31, 1'b1, 5'd31, 1'b1, 5'd2);
        check_both("R2 mem on B", 2'b00, 2'b10);
    endtask

    task automatic t_wb_only();             // R3
        apply(5'd12, 5'd13, 1'b1, 5'd20, 1'b1, 5'd12);
        check_both("R3 wb on A", 2'b01, 2'b00);
        apply(5'd13, 5'd13, 1'b0, 5'd13, 1'b1, 5'd13);
        check_both("R3 wb on both", 2'b01, 2'b01);
    endtask

    task automatic t_wen_low();             // R4
        apply(5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8);
        check_both("R4 both wen low", 2'b00, 2'b00);
    endtask

    task automatic t_zero_reg();            // R5
        apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
        check_both("R5 register zero", 2'b00, 2'b00);
        apply(5'd0, 5'd1, 1'b1, 5'd0, 1'b1, 5'd1);
        check_both("R5 zero mem, wb on B", 2'b00, 2'b01);
    endtask

    task automatic t_priority();            // R6
        apply(5'd9, 5'd9, 1'b1, 5'd9, 1'b1, 5'd9);
        check_both("R6 both stages match", 2'b10, 2'b10);
    endtask

    task automatic t_split();               // R7
        apply(5'd4, 5'd17, 1'b1, 5'd4, 1'b1, 5'd17);
        check_both("R7 A mem B wb", 2'b10, 2'b01);
        apply(5'd17, 5'd4, 1'b1, 5'd4, 1'b1, 5'd17);
        check_both("R7 A wb B mem", 2'b01, 2'b10);
    endtask

    task automatic t_sweep();               // R1..R8 reference sweep
        for (int s = 0; s < 32; s += 3) begin
            for (int d = 0; d < 32; d += 5) begin
                for (int e = 0; e < 4; e++) begin
                    logic [1:0] ea, eb;
                    apply(s[4:0], d[4:0], e[0], d[4:0], e[1], s[4:0]);
                    ea = ref_sel(s[4:0]);
                    eb = ref_sel(d[4:0]);
                    check_both("R8 sweep", ea, eb);
                    check("R8 sel_a not reserved", {31'b0, sel_a == 2'b11}, 32'd0);
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (2) @(posedge clk);
        t_idle();
        t_mem_only();
        t_wb_only();
        t_wen_low();
        t_zero_reg();
        t_priority();
        t_split();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule